// File: doc/BRIEF.md
# Selectable Machine-Cycle Clock Generator

This block turns the oscillator clock of an 8-bit microcontroller into machine-cycle timing. A machine cycle lasts either 12 oscillator periods (slow mode) or 6 (fast mode). A single-cycle strobe marks the last oscillator period of every machine cycle. A second strobe, one oscillator period later, serves as the clock enable for the serial port's fixed-rate modes.

Software selects the mode through one bit of a control register in the special-function space. A one-time-programmed configuration input can force fast mode whatever software writes. A new mode takes effect only where a machine cycle ends, so no cycle ever has a partial length.

The block also qualifies the external reset pin. The pin passes through a synchronizer, and the internal reset is asserted only after the pin has stayed high for two machine cycles of the mode in force. When the internal reset is released, the block captures the external-access pin and holds that value until the next release.

Top module: `mcyc_clkgen`

## Requirements
- R1: After the power-on reset `por`, the control bit reads 0 and the block runs in slow mode (when `cfg_x6` is 0). `int_rst` and `ea_lat` are both 0.
- R2: `mc_end` pulses for one cycle every 12 clocks in slow mode and every 6 clocks in fast mode. `mode_fast` shows the mode in force, with 1 meaning fast.
- R3: The control register sits at address 0x8F. Bit 0 is the mode bit, with 1 meaning fast. Bits 7:1 read 0, and writing them has no effect. A write to any other address has no effect, and a read of any other address returns 0.
- R4: A change of the selected mode takes effect only after the machine cycle in progress has finished at its old length.
- R5: While `cfg_x6` is 1, every machine cycle that starts is fast, whatever the register bit. The register still reads back the value software wrote.
- R6: `ser_fix_en` pulses exactly on the cycle after each `mc_end`, and at no other time.
- R7: `int_rst` rises after the clock edge on which `rst_pin` has been sampled high for 2×L+3 consecutive edges, where L is the machine-cycle length in force (L is 12 or 6). The 3 extra edges are synchronizer and flag latency.
- R8: A single edge on which `rst_pin` is sampled low clears the qualification count. Once asserted, `int_rst` stays high until `rst_pin` goes low, and then falls after the third edge on which the pin is low.
- R9: `ea_lat` takes the value of `ea_pin` on the edge where `int_rst` falls. At every other edge, changes on `ea_pin` leave it unchanged.
- R10: While `int_rst` is high, the mode bit is held at 0, and register writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por | input | 1 | Synchronous power-on reset, active high |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| ea_pin | input | 1 | External-access pin, captured at reset release |
| cfg_x6 | input | 1 | One-time-programmed override; 1 forces fast mode |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Special-function address for reads and writes |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr` |
| mc_end | output | 1 | Strobe on the last clock of each machine cycle |
| ser_fix_en | output | 1 | Clock enable for the fixed-rate serial modes |
| mode_fast | output | 1 | Mode in force, 1 meaning fast |
| int_rst | output | 1 | Qualified internal reset |
| ea_lat | output | 1 | Captured external-access value |

## Verification
A wrong divider count or a mode that switches early shows up within a single machine cycle as a strobe spacing other than 6 or 12. The bench measures that spacing right after writes that land in the middle of a cycle. A qualification counter that is not cleared, or a threshold taken from the wrong mode, moves the rising edge of `int_rst`. The bench therefore samples it one edge before and on the exact edge the requirement gives. A capture enable that is wrongly left open shows at `ea_lat` a few cycles after `ea_pin` toggles while no reset is being released.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int unsigned SFR_W = 8;

    typedef enum logic {
        MODE_SLOW = 1'b0,
        MODE_FAST = 1'b1
    } cyc_mode_e;

    typedef struct packed {
        logic             wr;
        logic [SFR_W-1:0] addr;
        logic [SFR_W-1:0] wdata;
    } sfr_req_t;

    // Nonvolatile override wins over the software selection.
    function automatic cyc_mode_e pick_mode(input logic otp_fast, input logic sw_fast);
        return (otp_fast || sw_fast) ? MODE_FAST : MODE_SLOW;
    endfunction

    function automatic int unsigned cyc_len(input cyc_mode_e m,
                                            input int unsigned fast_len,
                                            input int unsigned slow_len);
        return (m == MODE_FAST) ? fast_len : slow_len;
    endfunction

endpackage

// File: rtl/mcyc_sync.sv
module mcyc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic por,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (por) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (por) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mcyc_ctlreg.sv
module mcyc_ctlreg
    import mcyc_pkg::*;
#(
    parameter logic [SFR_W-1:0] CTL_ADDR = 8'h8F
) (
    input  logic             clk,
    input  logic             por,
    input  logic             int_rst,
    input  sfr_req_t         req,
    output logic [SFR_W-1:0] rdata,
    output logic             sw_fast
);
    logic hit;
    logic fast_q;

    assign hit = (req.addr == CTL_ADDR);

    // Only bit 0 is stored; reserved bits have no flops.
    always_ff @(posedge clk) begin
        if (por || int_rst)      fast_q <= 1'b0;
        else if (req.wr && hit)  fast_q <= req.wdata[0];
    end

    always_comb begin
        rdata = '0;
        if (hit) rdata[0] = fast_q;
    end

    assign sw_fast = fast_q;
endmodule

// File: rtl/mcyc_divider.sv
module mcyc_divider
    import mcyc_pkg::*;
#(
    parameter int unsigned FAST_LEN = 6,
    parameter int unsigned SLOW_LEN = 12
) (
    input  logic      clk,
    input  logic      por,
    input  cyc_mode_e sel_mode,
    output logic      mc_end,
    output cyc_mode_e act_mode,
    output logic      ser_fix_en
);
    localparam int unsigned CNT_W = $clog2(SLOW_LEN);

    cyc_mode_e        act_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;

    assign last_idx = CNT_W'(cyc_len(act_q, FAST_LEN, SLOW_LEN) - 1);
    assign mc_end   = (cnt_q == last_idx);

    // Mode is resampled only at the cycle boundary.
    always_ff @(posedge clk) begin
        if (por) begin
            cnt_q      <= '0;
            act_q      <= sel_mode;
            ser_fix_en <= 1'b0;
        end else begin
            ser_fix_en <= mc_end;
            if (mc_end) begin
                cnt_q <= '0;
                act_q <= sel_mode;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign act_mode = act_q;
endmodule

// File: rtl/mcyc_rstqual.sv
module mcyc_rstqual
    import mcyc_pkg::*;
#(
    parameter int unsigned FAST_LEN = 6,
    parameter int unsigned SLOW_LEN = 12,
    parameter int unsigned RST_MCYC = 2
) (
    input  logic      clk,
    input  logic      por,
    input  logic      pin_sync,
    input  cyc_mode_e act_mode,
    input  logic      ea_pin,
    output logic      int_rst,
    output logic      ea_lat
);
    localparam int unsigned QMAX = RST_MCYC * SLOW_LEN;
    localparam int unsigned Q_W  = $clog2(QMAX + 1);

    logic [Q_W-1:0] qcnt_q;
    logic [Q_W-1:0] thr;
    logic           rst_q;
    logic           ea_q;

    assign thr = Q_W'(RST_MCYC * cyc_len(act_mode, FAST_LEN, SLOW_LEN));

    always_ff @(posedge clk) begin
        if (por) begin
            qcnt_q <= '0;
            rst_q  <= 1'b0;
            ea_q   <= 1'b0;
        end else begin
            if (!pin_sync)        qcnt_q <= '0;
            else if (qcnt_q < thr) qcnt_q <= qcnt_q + 1'b1;

            // Sticky once set: a mode change during reset cannot drop it.
            if (!pin_sync)         rst_q <= 1'b0;
            else if (qcnt_q >= thr) rst_q <= 1'b1;

            if (rst_q && !pin_sync) ea_q <= ea_pin;
        end
    end

    assign int_rst = rst_q;
    assign ea_lat  = ea_q;
endmodule

// File: rtl/mcyc_clkgen.sv
module mcyc_clkgen
    import mcyc_pkg::*;
#(
    parameter int unsigned      FAST_LEN    = 6,
    parameter int unsigned      SLOW_LEN    = 12,
    parameter int unsigned      RST_MCYC    = 2,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [SFR_W-1:0] CTL_ADDR    = 8'h8F
) (
    input  logic             clk,
    input  logic             por,
    input  logic             rst_pin,
    input  logic             ea_pin,
    input  logic             cfg_x6,
    input  logic             sfr_wr,
    input  logic [SFR_W-1:0] sfr_addr,
    input  logic [SFR_W-1:0] sfr_wdata,
    output logic [SFR_W-1:0] sfr_rdata,
    output logic             mc_end,
    output logic             ser_fix_en,
    output logic             mode_fast,
    output logic             int_rst,
    output logic             ea_lat
);
    sfr_req_t  req;
    logic      pin_sync;
    logic      sw_fast;
    cyc_mode_e sel_mode;
    cyc_mode_e act_mode;

    assign req = '{wr: sfr_wr, addr: sfr_addr, wdata: sfr_wdata};

    mcyc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .por     (por),
        .d_async (rst_pin),
        .q_sync  (pin_sync)
    );

    mcyc_ctlreg #(.CTL_ADDR(CTL_ADDR)) i_ctl (
        .clk     (clk),
        .por     (por),
        .int_rst (int_rst),
        .req     (req),
        .rdata   (sfr_rdata),
        .sw_fast (sw_fast)
    );

    assign sel_mode = pick_mode(cfg_x6, sw_fast);

    mcyc_divider #(.FAST_LEN(FAST_LEN), .SLOW_LEN(SLOW_LEN)) i_div (
        .clk        (clk),
        .por        (por),
        .sel_mode   (sel_mode),
        .mc_end     (mc_end),
        .act_mode   (act_mode),
        .ser_fix_en (ser_fix_en)
    );

    mcyc_rstqual #(.FAST_LEN(FAST_LEN), .SLOW_LEN(SLOW_LEN), .RST_MCYC(RST_MCYC)) i_rq (
        .clk      (clk),
        .por      (por),
        .pin_sync (pin_sync),
        .act_mode (act_mode),
        .ea_pin   (ea_pin),
        .int_rst  (int_rst),
        .ea_lat   (ea_lat)
    );

    assign mode_fast = (act_mode == MODE_FAST);
endmodule

// File: rtl/mcyc_clkgen_chk.sv
module mcyc_clkgen_chk #(
    parameter int unsigned FAST_LEN = 6,
    parameter int unsigned SLOW_LEN = 12
) (
    input logic clk,
    input logic por,
    input logic rst_pin,
    input logic cfg_x6,
    input logic mc_end,
    input logic ser_fix_en,
    input logic mode_fast,
    input logic int_rst,
    input logic ea_lat
);
    int unsigned gap_q;

    always_ff @(posedge clk) begin
        if (por || mc_end) gap_q <= 0;
        else               gap_q <= gap_q + 1;
    end

    a_r2_cycle_len: assert property (@(posedge clk) disable iff (por)
        mc_end |-> (gap_q == (mode_fast ? FAST_LEN - 1 : SLOW_LEN - 1)));

    a_r4_mode_hold: assert property (@(posedge clk) disable iff (por)
        !mc_end |=> $stable(mode_fast));

    a_r5_otp_force: assert property (@(posedge clk) disable iff (por)
        (cfg_x6 && mc_end) |=> mode_fast);

    a_r6_ser_after_end: assert property (@(posedge clk) disable iff (por)
        mc_end |=> ser_fix_en);

    a_r6_ser_only: assert property (@(posedge clk) disable iff (por)
        !mc_end |=> !ser_fix_en);

    a_r8_release: assert property (@(posedge clk) disable iff (por)
        (!rst_pin && $past(!rst_pin) && $past(!rst_pin, 2)) |=> !int_rst);

    a_r9_ea_hold: assert property (@(posedge clk) disable iff (por)
        !int_rst |=> $stable(ea_lat));
endmodule

bind mcyc_clkgen mcyc_clkgen_chk #(.FAST_LEN(FAST_LEN), .SLOW_LEN(SLOW_LEN)) i_chk (
    .clk        (clk),
    .por        (por),
    .rst_pin    (rst_pin),
    .cfg_x6     (cfg_x6),
    .mc_end     (mc_end),
    .ser_fix_en (ser_fix_en),
    .mode_fast  (mode_fast),
    .int_rst    (int_rst),
    .ea_lat     (ea_lat)
);

// File: tb/test_mcyc_clkgen.sv
module test_mcyc_clkgen;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 6;
    // {write addr, write data, read addr, expected read}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h8F, 8'hFF, 8'h8F, 8'h01},
        {8'h8F, 8'hFE, 8'h8F, 8'h00},
        {8'h8F, 8'h03, 8'h8F, 8'h01},
        {8'h8E, 8'h00, 8'h8F, 8'h01},
        {8'h8E, 8'hFF, 8'h8E, 8'h00},
        {8'h8F, 8'h00, 8'h8F, 8'h00}
    };

    logic       clk = 0;
    logic       por = 1;
    logic       rst_pin = 0, ea_pin = 0, cfg_x6 = 0, sfr_wr = 0;
    logic [7:0] sfr_addr = 8'h8F, sfr_wdata = 0;
    logic [7:0] sfr_rdata;
    logic       mc_end, ser_fix_en, mode_fast, int_rst, ea_lat;

    int total = 0, bad = 0;
    int n;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mcyc_clkgen i_mcyc_clkgen (
        .clk(clk), .por(por), .rst_pin(rst_pin), .ea_pin(ea_pin), .cfg_x6(cfg_x6),
        .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .mc_end(mc_end), .ser_fix_en(ser_fix_en), .mode_fast(mode_fast),
        .int_rst(int_rst), .ea_lat(ea_lat)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_end();
        do @(negedge clk); while (!mc_end);
    endtask

    task automatic period(output int p);
        wait_end();
        p = 0;
        do begin @(negedge clk); p++; end while (!mc_end);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 0; sfr_addr = 8'h8F;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por = 0;
        // R1: reset state
        chk(sfr_rdata == 8'h00, "R1 reg", sfr_rdata, 0);
        chk(!int_rst && !ea_lat, "R1 rst/ea", {int_rst, ea_lat}, 0);
        chk(!mode_fast, "R1 mode", mode_fast, 0);
        period(n); chk(n == 12, "R2 slow period", n, 12);

        // R3: register table
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][31:24], VEC[i][23:16]);
            sfr_addr = VEC[i][15:8];
            #1;
            chk(sfr_rdata == VEC[i][7:0], "R3 table", sfr_rdata, VEC[i][7:0]);
            sfr_addr = 8'h8F;
        end
        period(n); period(n);
        chk(n == 12, "R2 slow again", n, 12);

        // R4: mid-cycle write keeps the running cycle at its old length
        wait_end();
        n = 0;
        repeat (3) begin @(negedge clk); n++; end
        wr(8'h8F, 8'h01); n++;
        while (!mc_end) begin @(negedge clk); n++; end
        chk(n == 12, "R4 old length kept", n, 12);
        n = 0;
        do begin @(negedge clk); n++; end while (!mc_end);
        chk(n == 6, "R2 fast period", n, 6);
        chk(mode_fast, "R2 mode flag", mode_fast, 1);

        // R6: serial enable one clock after the strobe
        wait_end();
        @(negedge clk);
        chk(ser_fix_en && !mc_end, "R6 ser enable", ser_fix_en, 1);
        @(negedge clk);
        chk(!ser_fix_en, "R6 ser single", ser_fix_en, 0);

        // R7: fast qualification, 2*6+3 = 15 edges
        rst_pin = 1;
        repeat (14) @(negedge clk);
        chk(!int_rst, "R7 fast early", int_rst, 0);
        @(negedge clk);
        chk(int_rst, "R7 fast on time", int_rst, 1);
        @(negedge clk);
        chk(sfr_rdata == 8'h00, "R10 bit cleared", sfr_rdata, 0);
        wr(8'h8F, 8'h01);
        chk(sfr_rdata == 8'h00, "R10 write ignored", sfr_rdata, 0);
        repeat (30) @(negedge clk);
        chk(int_rst, "R8 held", int_rst, 1);

        // R8/R9: release and capture
        ea_pin = 1;
        rst_pin = 0;
        repeat (2) @(negedge clk);
        chk(int_rst, "R8 release early", int_rst, 1);
        @(negedge clk);
        chk(!int_rst, "R8 release on time", int_rst, 0);
        chk(ea_lat, "R9 capture 1", ea_lat, 1);
        ea_pin = 0;
        repeat (10) @(negedge clk);
        chk(ea_lat, "R9 later change ignored", ea_lat, 1);

        // R7/R8: slow qualification with an interrupting low
        period(n); period(n);
        chk(n == 12 && !mode_fast, "R2 slow after reset", n, 12);
        rst_pin = 1;
        repeat (20) @(negedge clk);
        rst_pin = 0;
        @(negedge clk);
        rst_pin = 1;
        repeat (26) @(negedge clk);
        chk(!int_rst, "R8 count cleared", int_rst, 0);
        @(negedge clk);
        chk(int_rst, "R7 slow on time", int_rst, 1);
        ea_pin = 0;
        rst_pin = 0;
        repeat (3) @(negedge clk);
        chk(!int_rst && !ea_lat, "R9 capture 0", ea_lat, 0);
        ea_pin = 1;
        repeat (5) @(negedge clk);
        chk(!ea_lat, "R9 hold 0", ea_lat, 0);

        // R5: configuration override
        cfg_x6 = 1;
        period(n); period(n);
        chk(n == 6, "R5 forced fast", n, 6);
        chk(sfr_rdata == 8'h00, "R5 reg unchanged", sfr_rdata, 0);
        wr(8'h8F, 8'h01);
        period(n);
        chk(n == 6 && sfr_rdata == 8'h01, "R5 both set", n, 6);
        wr(8'h8F, 8'h00);
        cfg_x6 = 0;
        period(n); period(n);
        chk(n == 12, "R5 override off", n, 12);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule